// File: doc/BRIEF.md
# Repeating Block Memory Copy Engine

This engine moves a run of bytes from one place in a 64 KiB byte space to another. Software, or a sequencer, presents a source pointer, a destination pointer, a byte count, an initial flag byte and an accumulator value. It then pulses `start`. For every byte the engine first reads from the source address and then writes that byte to the destination address. After that it waits two internal clocks. It then advances both pointers, decrements the counter and updates the flag byte. If bytes remain, it idles five more clocks before the next pass. When the counter reaches zero it stops and pulses `done`.

Both memory ports are valid/ready. A cycle on either port lasts at least three clocks. While `*_valid` is high, the address, and for writes the data, stay stable until the cycle completes. The cycle completes on the first clock, from the third onward, in which the matching `*_ready` is high. Holding `ready` low stretches the cycle with no upper limit. `rd_data` is sampled only in the completing clock. Ready seen during the first two clocks of a cycle has no effect.

Flag byte layout, by bit: 7 sign, 6 zero, 5 copy of sum bit 5, 4 half-carry, 3 copy of sum bit 3, 2 parity/overflow, 1 subtract, 0 carry.

Top module: `blkcpy_engine`

## Requirements
- R1: Each pass first performs a read cycle at the source pointer, then a write cycle of the byte it read to the destination pointer. Each cycle lasts at least 3 clocks and is stretched while its ready is low. Valid and address stay stable until the cycle completes, and the two valids are never high together.
- R2: The update happens on the second internal clock after the write completes. It decrements the counter and increments both pointers, each wrapping modulo 65536 (0xFFFF is followed by 0x0000).
- R3: On every update, flag bits 5 and 3 take bits 5 and 3 of the 8-bit sum of `acc` and the copied byte, and flag bits 4 and 1 are cleared.
- R4: On every update, flag bit 2 is set if the decremented counter is nonzero and cleared if it is zero.
- R5: Flag bits 7, 6 and 0 keep the values loaded from `cfg_flags` at start for the whole run.
- R6: When the decremented counter is nonzero, the next read cycle starts after 5 further idle clocks. When it is zero, the run ends with no extra clocks, so a one-byte run with no stalls keeps `busy` high for exactly 8 clocks.
- R7: A start with `cfg_cnt` equal to 0 performs 65536 passes. After the first update, flag bit 2 is set and the engine stays busy.
- R8: `busy` is high from the clock after an accepted start until the final update. `done` is high for exactly one clock, the first clock in which `busy` is low again.
- R9: A `start` pulse while `busy` is high is ignored: the pointers, counter, flags and memory traffic of the run in progress are unchanged.
- R10: While reset is asserted (`rst_n` low), `busy`, `done`, `rd_valid` and `wr_valid` are low and `flags` is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Begin a run; accepted only when idle |
| cfg_src | input | 16 | Initial source pointer |
| cfg_dst | input | 16 | Initial destination pointer |
| cfg_cnt | input | 16 | Byte count (0 means 65536) |
| cfg_flags | input | 8 | Flag byte loaded at start |
| acc | input | 8 | Accumulator value added to each copied byte for flag bits 5 and 3 |
| rd_valid | output | 1 | Read cycle in progress |
| rd_ready | input | 1 | Memory completes the read (from the third clock on) |
| rd_addr | output | 16 | Read address |
| rd_data | input | 8 | Read data, sampled in the completing clock |
| wr_valid | output | 1 | Write cycle in progress |
| wr_ready | input | 1 | Memory completes the write (from the third clock on) |
| wr_addr | output | 16 | Write address |
| wr_data | output | 8 | Write data |
| flags | output | 8 | Current flag byte |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-clock pulse at the end of a run |

## Verification
The hardest case to reach is the zero-count start, which would need 65536 passes and far more clocks than a test may spend. The bench starts such a run, follows a few passes clock by clock to see flag bit 2 set and `busy` held, and then resets the engine in mid-run. Pointer wrap-around is reached by placing each pointer just below 0xFFFF in its own run, so the two regions never overlap. A periodic ready pattern that stalls across the minimum-length boundary exercises back-pressure.

// File: rtl/blkcpy_pkg.sv
package blkcpy_pkg;
  typedef enum logic [2:0] {
    PH_IDLE = 3'd0,
    PH_RD   = 3'd1,
    PH_WR   = 3'd2,
    PH_GAP  = 3'd3,
    PH_REP  = 3'd4
  } phase_t;

  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_B5   = 5;
  localparam int FB_HALF = 4;
  localparam int FB_B3   = 3;
  localparam int FB_PV   = 2;
  localparam int FB_SUB  = 1;
  localparam int FB_CARY = 0;
endpackage

// File: rtl/blkcpy_seq.sv
module blkcpy_seq
  import blkcpy_pkg::*;
#(
  parameter int MEM_CLKS = 3,
  parameter int GAP_CLKS = 2,
  parameter int REP_CLKS = 5
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic rd_ready,
  input  logic wr_ready,
  input  logic cnt_last,
  output logic rd_valid,
  output logic wr_valid,
  output logic load,
  output logic capture,
  output logic update,
  output logic busy,
  output logic done
);
  localparam int MAXC  = (MEM_CLKS > GAP_CLKS) ?
                         ((MEM_CLKS > REP_CLKS) ? MEM_CLKS : REP_CLKS) :
                         ((GAP_CLKS > REP_CLKS) ? GAP_CLKS : REP_CLKS);
  localparam int CYC_W = $clog2(MAXC + 1);
  localparam logic [CYC_W-1:0] MEM_END = CYC_W'(MEM_CLKS - 1);
  localparam logic [CYC_W-1:0] GAP_END = CYC_W'(GAP_CLKS - 1);
  localparam logic [CYC_W-1:0] REP_END = CYC_W'(REP_CLKS - 1);

  phase_t           ph;
  logic [CYC_W-1:0] cyc;
  logic             mem_min;
  logic             wr_fin;

  assign mem_min  = (cyc == MEM_END);
  assign rd_valid = (ph == PH_RD);
  assign wr_valid = (ph == PH_WR);
  assign busy     = (ph != PH_IDLE);
  assign load     = (ph == PH_IDLE) && start;
  assign capture  = rd_valid && mem_min && rd_ready;
  assign wr_fin   = wr_valid && mem_min && wr_ready;
  assign update   = (ph == PH_GAP) && (cyc == GAP_END);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ph   <= PH_IDLE;
      cyc  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (ph)
        PH_IDLE: if (start) begin
          ph  <= PH_RD;
          cyc <= '0;
        end
        PH_RD, PH_WR: begin
          if (capture || wr_fin) begin
            ph  <= rd_valid ? PH_WR : PH_GAP;
            cyc <= '0;
          end else if (!mem_min) begin
            cyc <= cyc + 1'b1;
          end
        end
        PH_GAP: begin
          if (update) begin
            cyc <= '0;
            if (cnt_last) begin
              ph   <= PH_IDLE;
              done <= 1'b1;
            end else begin
              ph <= PH_REP;
            end
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        PH_REP: begin
          if (cyc == REP_END) begin
            ph  <= PH_RD;
            cyc <= '0;
          end else begin
            cyc <= cyc + 1'b1;
          end
        end
        default: ph <= PH_IDLE;
      endcase
    end
  end

  AST_RW_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(rd_valid && wr_valid)); // R1
  AST_RD_MIN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rd_valid) |=> rd_valid); // R1
  AST_DONE_ONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && $past(busy))); // R8
  AST_START_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && start && !update) |=> busy); // R9
endmodule

// File: rtl/blkcpy_regs.sv
module blkcpy_regs
  import blkcpy_pkg::*;
#(
  parameter int AW = 16,
  parameter int CW = 16,
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic          capture,
  input  logic          update,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [7:0]    cfg_flags,
  input  logic [DW-1:0] acc,
  input  logic [DW-1:0] rd_data,
  output logic [AW-1:0] src,
  output logic [AW-1:0] dst,
  output logic          cnt_last,
  output logic [DW-1:0] held,
  output logic [7:0]    flags
);
  localparam logic [CW-1:0] CNT_ONE = CW'(1);

  logic [CW-1:0] cnt;
  logic [CW-1:0] cnt_nxt;
  logic [DW-1:0] sum;
  logic [7:0]    flg_nxt;

  assign cnt_nxt  = cnt - 1'b1;
  assign cnt_last = (cnt == CNT_ONE);
  assign sum      = acc + held;

  always_comb begin
    flg_nxt          = flags;
    flg_nxt[FB_B5]   = sum[5];
    flg_nxt[FB_B3]   = sum[3];
    flg_nxt[FB_HALF] = 1'b0;
    flg_nxt[FB_SUB]  = 1'b0;
    flg_nxt[FB_PV]   = |cnt_nxt;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src   <= '0;
      dst   <= '0;
      cnt   <= '0;
      held  <= '0;
      flags <= '0;
    end else if (load) begin
      src   <= cfg_src;
      dst   <= cfg_dst;
      cnt   <= cfg_cnt;
      flags <= cfg_flags;
    end else begin
      if (capture) held <= rd_data;
      if (update) begin
        src   <= src + 1'b1;
        dst   <= dst + 1'b1;
        cnt   <= cnt_nxt;
        flags <= flg_nxt;
      end
    end
  end

  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (src == AW'($past(src) + 1'b1)) && (dst == AW'($past(dst) + 1'b1))); // R2
  AST_PV_TRACKS: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (flags[FB_PV] == (cnt != '0))); // R4
  AST_HN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    update |=> (!flags[FB_HALF] && !flags[FB_SUB])); // R3
  AST_SZC_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
    !load |=> ($stable(flags[FB_SIGN]) && $stable(flags[FB_ZERO]) && $stable(flags[FB_CARY]))); // R5
endmodule

// File: rtl/blkcpy_engine.sv
module blkcpy_engine #(
  parameter int AW       = 16,
  parameter int CW       = 16,
  parameter int DW       = 8,
  parameter int MEM_CLKS = 3,
  parameter int GAP_CLKS = 2,
  parameter int REP_CLKS = 5
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start,
  input  logic [AW-1:0] cfg_src,
  input  logic [AW-1:0] cfg_dst,
  input  logic [CW-1:0] cfg_cnt,
  input  logic [7:0]    cfg_flags,
  input  logic [DW-1:0] acc,
  output logic          rd_valid,
  input  logic          rd_ready,
  output logic [AW-1:0] rd_addr,
  input  logic [DW-1:0] rd_data,
  output logic          wr_valid,
  input  logic          wr_ready,
  output logic [AW-1:0] wr_addr,
  output logic [DW-1:0] wr_data,
  output logic [7:0]    flags,
  output logic          busy,
  output logic          done
);
  logic load, capture, update, cnt_last;

  blkcpy_seq #(
    .MEM_CLKS(MEM_CLKS), .GAP_CLKS(GAP_CLKS), .REP_CLKS(REP_CLKS)
  ) u_seq (
    .clk(clk), .rst_n(rst_n), .start(start),
    .rd_ready(rd_ready), .wr_ready(wr_ready), .cnt_last(cnt_last),
    .rd_valid(rd_valid), .wr_valid(wr_valid),
    .load(load), .capture(capture), .update(update),
    .busy(busy), .done(done)
  );

  blkcpy_regs #(.AW(AW), .CW(CW), .DW(DW)) u_regs (
    .clk(clk), .rst_n(rst_n),
    .load(load), .capture(capture), .update(update),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .cfg_flags(cfg_flags), .acc(acc), .rd_data(rd_data),
    .src(rd_addr), .dst(wr_addr), .cnt_last(cnt_last),
    .held(wr_data), .flags(flags)
  );

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_addr))); // R1
  AST_WR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && !wr_ready) |=> (wr_valid && $stable(wr_addr) && $stable(wr_data))); // R1
endmodule

// File: tb/sim_blkcpy_engine.sv
module sim_blkcpy_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [15:0] cfg_src = '0, cfg_dst = '0, cfg_cnt = '0;
  logic [7:0]  cfg_flags = '0, acc = '0;
  logic        rd_valid, wr_valid, busy, done;
  logic        rd_ready = 1'b1, wr_ready = 1'b1;
  logic [15:0] rd_addr, wr_addr;
  logic [7:0]  rd_data = '0, wr_data, flags;

  always #10 clk = ~clk;

  blkcpy_engine u0 (
    .clk(clk), .rst_n(rst_n), .start(start),
    .cfg_src(cfg_src), .cfg_dst(cfg_dst), .cfg_cnt(cfg_cnt),
    .cfg_flags(cfg_flags), .acc(acc),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_addr(rd_addr), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_ready(wr_ready), .wr_addr(wr_addr), .wr_data(wr_data),
    .flags(flags), .busy(busy), .done(done)
  );

  int checks = 0, fails = 0, tick = 0;
  bit stall = 0, finished = 0;
  logic [7:0] mem [int];

  function automatic logic [7:0] seed_val(int a);
    return 8'((a * 37 + (a >> 8) * 11 + 5) & 255);
  endfunction
  function automatic logic [7:0] memrd(int a);
    return mem.exists(a) ? mem[a] : seed_val(a);
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // behavioural reference model
  int m_ph = 0, m_k = 0;
  int m_src = 0, m_dst = 0, m_cnt = 0, m_byte = 0, m_flags = 0;
  bit m_done = 0;
  always @(posedge clk) begin
    if (!rst_n) begin
      m_ph = 0; m_k = 0; m_src = 0; m_dst = 0; m_cnt = 0;
      m_byte = 0; m_flags = 0; m_done = 0;
    end else begin
      m_done = 0;
      case (m_ph)
        0: if (start) begin
             m_src = cfg_src; m_dst = cfg_dst; m_cnt = cfg_cnt;
             m_flags = cfg_flags; m_ph = 1; m_k = 0;
           end
        1: if (m_k >= 2 && rd_ready) begin
             m_byte = memrd(m_src); m_ph = 2; m_k = 0;
           end else if (m_k < 2) m_k++;
        2: if (m_k >= 2 && wr_ready) begin
             mem[m_dst] = 8'(m_byte); m_ph = 3; m_k = 0;
           end else if (m_k < 2) m_k++;
        3: if (m_k == 1) begin
             int s;
             m_cnt = (m_cnt - 1) & 16'hFFFF;
             m_src = (m_src + 1) & 16'hFFFF;
             m_dst = (m_dst + 1) & 16'hFFFF;
             s = (acc + m_byte) & 255;
             m_flags = (m_flags & 8'hC1) | (s & 8'h28) | ((m_cnt != 0) ? 4 : 0);
             m_k = 0;
             if (m_cnt != 0) m_ph = 4;
             else begin m_ph = 0; m_done = 1; end
           end else m_k++;
        4: if (m_k == 4) begin m_ph = 1; m_k = 0; end else m_k++;
        default: m_ph = 0;
      endcase
    end
  end

  // compare every clock away from the edge, then drive memory responses
  always @(negedge clk) begin
    tick++;
    if (rst_n && !finished) begin
      chk(busy == (m_ph != 0), "R8", "busy", busy, m_ph != 0);
      chk(done == m_done, "R8", "done", done, m_done);
      chk(rd_valid == (m_ph == 1), "R1", "rd_valid", rd_valid, m_ph == 1);
      chk(wr_valid == (m_ph == 2), "R6", "wr_valid", wr_valid, m_ph == 2);
      if (rd_valid) chk(rd_addr == 16'(m_src), "R2", "rd_addr", rd_addr, m_src);
      if (wr_valid) begin
        chk(wr_addr == 16'(m_dst), "R2", "wr_addr", wr_addr, m_dst);
        chk(wr_data == 8'(m_byte), "R1", "wr_data", wr_data, m_byte);
      end
      chk(flags == 8'(m_flags), "R3", "flags", flags, m_flags);
    end
    rd_data  <= memrd(rd_addr);
    rd_ready <= stall ? ((tick % 4) == 1) : 1'b1;
    wr_ready <= stall ? ((tick % 3) == 0) : 1'b1;
  end

  task automatic launch(int s, int d, int n, int f, int a);
    @(negedge clk);
    cfg_src = 16'(s); cfg_dst = 16'(d); cfg_cnt = 16'(n);
    cfg_flags = 8'(f); acc = 8'(a); start = 1'b1;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic wait_done(output int busy_clks);
    busy_clks = 1;
    while (!done) begin
      @(negedge clk);
      if (busy) busy_clks++;
    end
  endtask

  task automatic check_copy(int s, int d, int n, string req);
    for (int i = 0; i < n; i++)
      chk(memrd((d + i) & 16'hFFFF) == seed_val((s + i) & 16'hFFFF), req, "copied byte",
          memrd((d + i) & 16'hFFFF), seed_val((s + i) & 16'hFFFF));
  endtask

  initial begin
    int bc;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk({busy, done, rd_valid, wr_valid} == 4'b0, "R10", "ctrl in reset", {busy, done, rd_valid, wr_valid}, 0);
    chk(flags == 8'h00, "R10", "flags in reset", flags, 0);
    rst_n = 1'b1;

    // R1 R3 R5 basic run, no stalls
    launch(16'h1000, 16'h2000, 4, 8'hC1, 8'h05);
    wait_done(bc);
    check_copy(16'h1000, 16'h2000, 4, "R1");
    chk(flags[2] == 1'b0, "R4", "pv at end", flags[2], 0);
    chk({flags[7:6], flags[0]} == 3'b111, "R5", "szc kept", {flags[7:6], flags[0]}, 7);
    chk(busy_is_low(), "R8", "busy after done", busy, 0);

    // R6 single byte: exactly 8 busy clocks; two bytes: 21
    launch(16'h3000, 16'h3100, 1, 8'h00, 8'h33);
    wait_done(bc);
    chk(bc == 8, "R6", "busy clocks n=1", bc, 8);
    launch(16'h3200, 16'h3300, 2, 8'h00, 8'h0C);
    wait_done(bc);
    chk(bc == 21, "R6", "busy clocks n=2", bc, 21);

    // R1 back-pressure on both ports
    stall = 1;
    launch(16'h4400, 16'h4800, 5, 8'h40, 8'hF0);
    wait_done(bc);
    check_copy(16'h4400, 16'h4800, 5, "R1");
    stall = 0;

    // R2 pointer wrap, source then destination
    launch(16'hFFFE, 16'h6000, 4, 8'h80, 8'h11);
    wait_done(bc);
    check_copy(16'hFFFE, 16'h6000, 4, "R2");
    launch(16'h5000, 16'hFFFD, 4, 8'h01, 8'h22);
    wait_done(bc);
    check_copy(16'h5000, 16'hFFFD, 4, "R2");

    // R9 start while busy is ignored
    launch(16'h7000, 16'h7400, 3, 8'h00, 8'h07);
    repeat (6) @(negedge clk);
    cfg_src = 16'h9000; cfg_dst = 16'h9400; cfg_cnt = 16'd9; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    wait_done(bc);
    check_copy(16'h7000, 16'h7400, 3, "R9");
    chk(memrd(16'h9400) == seed_val(16'h9400), "R9", "no stray write", memrd(16'h9400), seed_val(16'h9400));

    // R7 zero count wraps to 65536 passes; observe, then reset
    launch(16'hA000, 16'hB000, 0, 8'h00, 8'h00);
    repeat (40) @(negedge clk);
    chk(busy == 1'b1, "R7", "still busy", busy, 1);
    chk(flags[2] == 1'b1, "R7", "pv set after wrap", flags[2], 1);
    rst_n = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk({busy, rd_valid, wr_valid} == 3'b0, "R10", "mid-run reset", {busy, rd_valid, wr_valid}, 0);
    chk(flags == 8'h00, "R10", "flags after reset", flags, 0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  function automatic bit busy_is_low();
    return busy == 1'b0;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      finished = 1;
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule